// File: doc/BRIEF.md
# Receive Packet Buffer Controller

This block sits between a byte-level serial receiver (keyboard-style two-wire link or asynchronous serial framing) and a small receive buffer held in firmware-visible memory. Each byte that the receiver presents is written straight into the buffer at the next offset. The block counts bytes against a programmable packet length. When a packet is complete, the write offset returns to zero and a completion event is raised.

Firmware and hardware share one arming bit. Firmware sets the bit once it has consumed the previous packet, and only the block can clear it, which it does when the next packet completes. A packet that completes while the bit is clear is flagged as an overrun. Line errors on received bytes and aborted transfers raise a communication-error flag. The three flags are sticky, firmware clears them by writing 1 to them, and each one reaches the interrupt line through its own mask bit. Firmware can also read the offset of the most recently written byte.

Top module: `rx_pkt_ctrl`

## Requirements
- R1: After reset, `rdy` is 0, `flag_o` is 0, `mask_o` is 0, `last_ofs` is 0, `irq` is 0, and the first byte goes to offset 0.
- R2: In the cycle in which `rx_valid` is high, `buf_we` is high, `buf_wdata` equals `rx_data`, and `buf_addr` is the byte's position within the current packet. Positions count 0, 1, 2 and so on.
- R3: The packet length is `cfg_pkt_size`, and a value of 0 means BUF_BYTES. On the cycle after the last byte of a packet is accepted, done (`flag_o` bit 0) is 1 and the next byte goes to offset 0.
- R4: A firmware write to `rdy` with data 1 sets it, and a write with data 0 leaves it unchanged. If a set and a packet completion fall in the same cycle, `rdy` ends up set.
- R5: A packet that completes while `rdy` is 1 clears `rdy` on the following cycle. `rdy` falls in no other case.
- R6: A packet that completes while `rdy` is 0 sets overrun (`flag_o` bit 1) in addition to done.
- R7: A byte that arrives with `rx_frame_err` or `rx_parity_err` sets comm-error (`flag_o` bit 2). That byte is still stored and counted. A pulse on `rx_abort` sets comm-error and writes nothing.
- R8: From the cycle after each accepted byte, `last_ofs` holds the offset that byte was written to.
- R9: Flags stay set until firmware writes 1 to their bit of `fw_flag_clr`. If a flag's set event and its clear fall in the same cycle, the flag stays set.
- R10: `fw_mask_we` loads `mask_o` as a whole. `irq` is 1 exactly when some bit is set in both `flag_o` and `mask_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | Receiver presents a byte this cycle |
| rx_data | input | 8 | Received byte |
| rx_frame_err | input | 1 | Framing error on this byte |
| rx_parity_err | input | 1 | Parity error on this byte |
| rx_abort | input | 1 | Transfer aborted by the far end (pulse) |
| cfg_pkt_size | input | OFS_W | Packet length; 0 selects the full buffer |
| fw_rdy_we | input | 1 | Firmware write strobe for the arming bit |
| fw_rdy_wdata | input | 1 | Data for the arming bit (only 1 acts) |
| fw_flag_clr_we | input | 1 | Firmware write strobe for flag clearing |
| fw_flag_clr | input | 3 | Write-1-to-clear bits {comm, overrun, done} |
| fw_mask_we | input | 1 | Firmware write strobe for the mask |
| fw_mask_wdata | input | 3 | New mask value |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | OFS_W | Buffer write offset |
| buf_wdata | output | 8 | Buffer write data |
| rdy | output | 1 | Arming bit |
| flag_o | output | 3 | Interrupt flags {comm, overrun, done} |
| mask_o | output | 3 | Interrupt mask |
| last_ofs | output | OFS_W | Offset of the most recently written byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `rx_valid` and `rx_abort` stay low while the internal reset is still being released, and that `cfg_pkt_size` holds steady for the whole of a packet. The bench respects both. It waits several cycles after reset before it drives anything, and it changes the packet length only after a completion has brought the offset back to zero. The bench also never pulses `rx_abort` in the same cycle as a byte, so each comm-error event has a single cause.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  localparam int DATA_W  = 8;
  localparam int FLAG_N  = 3;
  localparam int FI_DONE = 0;
  localparam int FI_OVR  = 1;
  localparam int FI_COMM = 2;
  typedef logic [FLAG_N-1:0] flag_vec_t;
endpackage

// File: rtl/rpc_rst_sync.sv
module rpc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/rpc_ofs_ctr.sv
module rpc_ofs_ctr #(
  parameter int BUF_BYTES = 16,
  parameter int OFS_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_ok,
  input  logic [OFS_W-1:0] cfg_size,
  output logic [OFS_W-1:0] wr_ofs,
  output logic [OFS_W-1:0] last_ofs,
  output logic             pkt_end
);
  localparam logic [OFS_W:0] FULL_LEN = (OFS_W+1)'(BUF_BYTES);

  logic [OFS_W:0]   size_ext;
  logic [OFS_W:0]   pkt_len;
  logic [OFS_W:0]   ofs_plus1;
  logic             at_last;
  logic [OFS_W-1:0] wr_ofs_d;
  logic [OFS_W-1:0] last_ofs_d;

  always_comb begin
    size_ext = {1'b0, cfg_size};
    if (cfg_size == '0 || size_ext > FULL_LEN) pkt_len = FULL_LEN;
    else                                       pkt_len = size_ext;
    ofs_plus1 = {1'b0, wr_ofs} + 1'b1;
    at_last   = (ofs_plus1 >= pkt_len);
    pkt_end   = byte_ok & at_last;
  end

  always_comb begin
    wr_ofs_d   = wr_ofs;
    last_ofs_d = last_ofs;
    if (byte_ok) begin
      last_ofs_d = wr_ofs;
      if (at_last) wr_ofs_d = '0;
      else         wr_ofs_d = ofs_plus1[OFS_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ofs   <= '0;
      last_ofs <= '0;
    end else if (byte_ok) begin
      wr_ofs   <= wr_ofs_d;
      last_ofs <= last_ofs_d;
    end
  end
endmodule

// File: rtl/rpc_rdy_hs.sv
module rpc_rdy_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic set_we,
  input  logic set_data,
  input  logic pkt_end,
  output logic rdy,
  output logic done_evt,
  output logic ovr_evt
);
  logic set_req;
  logic rdy_d;
  logic rdy_en;

  always_comb begin
    set_req  = set_we & set_data;
    rdy_en   = set_req | pkt_end;
    rdy_d    = set_req | (rdy & ~pkt_end);
    done_evt = pkt_end;
    ovr_evt  = pkt_end & ~rdy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdy <= 1'b0;
    else if (rdy_en) rdy <= rdy_d;
  end
endmodule

// File: rtl/rpc_irq_regs.sv
module rpc_irq_regs
  import rpc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t set_vec,
  input  logic      clr_we,
  input  flag_vec_t clr_vec,
  input  logic      mask_we,
  input  flag_vec_t mask_wdata,
  output flag_vec_t flags,
  output flag_vec_t mask,
  output logic      irq
);
  flag_vec_t flags_d;
  flag_vec_t clr_eff;

  always_comb begin
    clr_eff = clr_we ? clr_vec : '0;
    for (int b = 0; b < FLAG_N; b++) begin
      flags_d[b] = set_vec[b] | (flags[b] & ~clr_eff[b]);
    end
    irq = |(flags & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= '0;
    else if (mask_we) mask <= mask_wdata;
  end
endmodule

// File: rtl/rx_pkt_ctrl.sv
module rx_pkt_ctrl
  import rpc_pkg::*;
#(
  parameter int BUF_BYTES = 16,
  parameter int OFS_W     = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_frame_err,
  input  logic              rx_parity_err,
  input  logic              rx_abort,
  input  logic [OFS_W-1:0]  cfg_pkt_size,
  input  logic              fw_rdy_we,
  input  logic              fw_rdy_wdata,
  input  logic              fw_flag_clr_we,
  input  logic [FLAG_N-1:0] fw_flag_clr,
  input  logic              fw_mask_we,
  input  logic [FLAG_N-1:0] fw_mask_wdata,
  output logic              buf_we,
  output logic [OFS_W-1:0]  buf_addr,
  output logic [DATA_W-1:0] buf_wdata,
  output logic              rdy,
  output logic [FLAG_N-1:0] flag_o,
  output logic [FLAG_N-1:0] mask_o,
  output logic [OFS_W-1:0]  last_ofs,
  output logic              irq
);
  logic      rst_n_i;
  logic      byte_ok;
  logic      pkt_end;
  logic      done_evt;
  logic      ovr_evt;
  logic      comm_evt;
  flag_vec_t set_vec;

  rpc_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_i)
  );

  always_comb begin
    byte_ok  = rx_valid & rst_n_i;
    comm_evt = rst_n_i & ((rx_valid & (rx_frame_err | rx_parity_err)) | rx_abort);
  end

  rpc_ofs_ctr #(.BUF_BYTES(BUF_BYTES), .OFS_W(OFS_W)) u_ofs (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .byte_ok  (byte_ok),
    .cfg_size (cfg_pkt_size),
    .wr_ofs   (buf_addr),
    .last_ofs (last_ofs),
    .pkt_end  (pkt_end)
  );

  rpc_rdy_hs u_hs (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .set_we   (fw_rdy_we),
    .set_data (fw_rdy_wdata),
    .pkt_end  (pkt_end),
    .rdy      (rdy),
    .done_evt (done_evt),
    .ovr_evt  (ovr_evt)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[FI_DONE] = done_evt;
    set_vec[FI_OVR]  = ovr_evt;
    set_vec[FI_COMM] = comm_evt;
  end

  rpc_irq_regs u_irq (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .set_vec    (set_vec),
    .clr_we     (fw_flag_clr_we),
    .clr_vec    (fw_flag_clr),
    .mask_we    (fw_mask_we),
    .mask_wdata (fw_mask_wdata),
    .flags      (flag_o),
    .mask       (mask_o),
    .irq        (irq)
  );

  assign buf_we    = byte_ok;
  assign buf_wdata = rx_data;
endmodule

// File: rtl/rx_pkt_ctrl_chk.sv
module rx_pkt_ctrl_chk
  import rpc_pkg::*;
#(
  parameter int BUF_BYTES = 16,
  parameter int OFS_W     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fw_rdy_we,
  input logic              fw_rdy_wdata,
  input logic              fw_flag_clr_we,
  input logic [FLAG_N-1:0] fw_flag_clr,
  input logic              buf_we,
  input logic [OFS_W-1:0]  buf_addr,
  input logic              rdy,
  input logic [FLAG_N-1:0] flag_o,
  input logic [OFS_W-1:0]  last_ofs
);
  // R5
  rdy_hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> $past(buf_we));

  // R6
  ovr_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o[FI_OVR]) |-> ($past(!rdy) && $past(buf_we) && flag_o[FI_DONE]));

  // R5
  done_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_o[FI_DONE]) && $past(rdy) && !$past(fw_rdy_we && fw_rdy_wdata)) |-> !rdy);

  // R8
  last_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |=> (last_ofs == $past(buf_addr)));

  // R2
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(buf_addr) < BUF_BYTES));

  for (genvar g = 0; g < FLAG_N; g++) begin : g_sticky
    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[g] && !(fw_flag_clr_we && fw_flag_clr[g])) |=> flag_o[g]);
  end
endmodule

bind rx_pkt_ctrl rx_pkt_ctrl_chk #(.BUF_BYTES(BUF_BYTES), .OFS_W(OFS_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .fw_rdy_we      (fw_rdy_we),
  .fw_rdy_wdata   (fw_rdy_wdata),
  .fw_flag_clr_we (fw_flag_clr_we),
  .fw_flag_clr    (fw_flag_clr),
  .buf_we         (buf_we),
  .buf_addr       (buf_addr),
  .rdy            (rdy),
  .flag_o         (flag_o),
  .last_ofs       (last_ofs)
);

// File: tb/test_rx_pkt_ctrl.sv
module test_rx_pkt_ctrl;
  localparam int NB = 16;
  localparam int OW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rx_valid, rx_frame_err, rx_parity_err, rx_abort;
  logic [7:0]    rx_data;
  logic [OW-1:0] cfg_pkt_size;
  logic          fw_rdy_we, fw_rdy_wdata, fw_flag_clr_we, fw_mask_we;
  logic [2:0]    fw_flag_clr, fw_mask_wdata;
  logic          buf_we, rdy, irq;
  logic [OW-1:0] buf_addr, last_ofs;
  logic [7:0]    buf_wdata;
  logic [2:0]    flag_o, mask_o;

  int vecs = 0;
  int errs = 0;
  bit finished = 0;
  logic [7:0] mem [NB];

  always #5 clk = ~clk;

  rx_pkt_ctrl #(.BUF_BYTES(NB)) i_rx_pkt_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err), .rx_abort(rx_abort),
    .cfg_pkt_size(cfg_pkt_size), .fw_rdy_we(fw_rdy_we), .fw_rdy_wdata(fw_rdy_wdata),
    .fw_flag_clr_we(fw_flag_clr_we), .fw_flag_clr(fw_flag_clr),
    .fw_mask_we(fw_mask_we), .fw_mask_wdata(fw_mask_wdata),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata), .rdy(rdy),
    .flag_o(flag_o), .mask_o(mask_o), .last_ofs(last_ofs), .irq(irq)
  );

  always @(posedge clk) if (buf_we) mem[buf_addr] <= buf_wdata;

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic quiet();
    rx_valid = 0; rx_frame_err = 0; rx_parity_err = 0; rx_abort = 0;
    fw_rdy_we = 0; fw_rdy_wdata = 0; fw_flag_clr_we = 0; fw_flag_clr = 0;
    fw_mask_we = 0; fw_mask_wdata = 0;
  endtask

  task automatic send(input logic [7:0] d, input logic fe, input logic pe, input int ofs);
    rx_valid = 1; rx_data = d; rx_frame_err = fe; rx_parity_err = pe;
    #1;
    chk("R2 buf_we", int'(buf_we), 1);
    chk("R2 buf_addr", int'(buf_addr), ofs);
    chk("R2 buf_wdata", int'(buf_wdata), int'(d));
    @(negedge clk);
    quiet();
  endtask

  task automatic arm(input logic v);
    fw_rdy_we = 1; fw_rdy_wdata = v;
    @(negedge clk);
    quiet();
  endtask

  task automatic clr(input logic [2:0] m);
    fw_flag_clr_we = 1; fw_flag_clr = m;
    @(negedge clk);
    quiet();
  endtask

  task automatic set_mask(input logic [2:0] m);
    fw_mask_we = 1; fw_mask_wdata = m;
    @(negedge clk);
    quiet();
  endtask

  function automatic logic [7:0] pat(input int s, input int i);
    return 8'((s * 37 + i * 11 + 5) & 255);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    quiet();
    rx_data = 0; cfg_pkt_size = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 rdy", int'(rdy), 0);
    chk("R1 flags", int'(flag_o), 0);
    chk("R1 mask", int'(mask_o), 0);
    chk("R1 last_ofs", int'(last_ofs), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 buf_addr", int'(buf_addr), 0);

    // R3 R5 R8 sweep over every packet size
    for (int s = 0; s < NB; s++) begin
      int len;
      len = (s == 0) ? NB : s;
      cfg_pkt_size = OW'(s);
      clr(3'b111);
      set_mask(3'b001);
      arm(1'b1);
      chk("R4 set", int'(rdy), 1);
      for (int i = 0; i < len; i++) begin
        send(pat(s, i), 1'b0, 1'b0, i);
        chk("R8 last_ofs", int'(last_ofs), i);
        if (i < len - 1) begin
          chk("R3 done early", int'(flag_o[0]), 0);
          chk("R5 rdy held", int'(rdy), 1);
        end
      end
      chk("R3 flags done only", int'(flag_o), 1);
      chk("R5 rdy cleared", int'(rdy), 0);
      chk("R10 irq done", int'(irq), 1);
      chk("R3 wrap", int'(buf_addr), 0);
      for (int i = 0; i < len; i++) chk("R2 stored", int'(mem[i]), int'(pat(s, i)));
    end

    // R10 mask sweep with done alone set
    for (int m = 0; m < 8; m++) begin
      set_mask(3'(m));
      chk("R10 mask", int'(mask_o), m);
      chk("R10 irq", int'(irq), m & 1);
    end

    // R6 overrun when unarmed
    cfg_pkt_size = 4;
    clr(3'b111);
    chk("R9 cleared", int'(flag_o), 0);
    for (int i = 0; i < 4; i++) send(8'(i), 1'b0, 1'b0, i);
    chk("R6 done+ovr", int'(flag_o), 3);
    chk("R6 rdy", int'(rdy), 0);

    // R4 writes of 0 ignored
    arm(1'b0);
    chk("R4 zero while clear", int'(rdy), 0);
    arm(1'b1);
    arm(1'b0);
    chk("R4 zero while set", int'(rdy), 1);
    clr(3'b111);
    for (int i = 0; i < 4; i++) send(8'(i + 100), 1'b0, 1'b0, i);
    chk("R5 armed done", int'(flag_o), 1);
    chk("R5 rdy", int'(rdy), 0);

    // R7 line errors and abort
    clr(3'b111);
    send(8'hA1, 1'b1, 1'b0, 0);
    chk("R7 frame", int'(flag_o), 4);
    chk("R7 frame ofs", int'(last_ofs), 0);
    clr(3'b100);
    send(8'hA2, 1'b0, 1'b1, 1);
    chk("R7 parity", int'(flag_o), 4);
    chk("R7 parity ofs", int'(last_ofs), 1);
    clr(3'b100);
    chk("R9 comm cleared", int'(flag_o), 0);
    rx_abort = 1;
    #1 chk("R7 abort no write", int'(buf_we), 0);
    @(negedge clk); quiet();
    chk("R7 abort", int'(flag_o), 4);
    chk("R7 abort ofs", int'(last_ofs), 1);
    send(8'hA3, 1'b0, 1'b0, 2);
    send(8'hA4, 1'b0, 1'b0, 3);
    chk("R7 error bytes counted", int'(flag_o), 7);
    chk("R7 stored", int'(mem[0]), 8'hA1);

    // R10 all flags set, mask sweep
    for (int m = 0; m < 8; m++) begin
      set_mask(3'(m));
      chk("R10 irq all", int'(irq), (m != 0) ? 1 : 0);
    end

    // R9 set wins over clear
    clr(3'b111);
    rx_abort = 1; fw_flag_clr_we = 1; fw_flag_clr = 3'b100;
    @(negedge clk); quiet();
    chk("R9 set wins", int'(flag_o), 4);
    clr(3'b010);
    chk("R9 other bit clear", int'(flag_o), 4);
    clr(3'b100);
    chk("R9 clear", int'(flag_o), 0);

    // R4 arm and completion in the same cycle
    cfg_pkt_size = 1;
    arm(1'b1);
    rx_valid = 1; rx_data = 8'h5A; fw_rdy_we = 1; fw_rdy_wdata = 1;
    @(negedge clk); quiet();
    chk("R4 same-cycle rdy", int'(rdy), 1);
    chk("R4 same-cycle flags", int'(flag_o), 1);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule